// File: doc/BRIEF.md
# PWM Output Polarity Stage

This block sits at the output of a three-channel capture/compare PWM unit. It drives seven pins: one compare output per channel, one complementary output per channel, and one extra output that a second timer owns. The timers, dead-time insertion and modulation logic sit upstream. They report for each pin whether it is currently active or passive. This stage turns that state into a pin level that suits the polarity of the power stage connected to it.

Each pin has a programmable idle ("passive") level. A pin in the passive state drives that level, and a pin in the active state drives its inverse. The levels are double-buffered. A bus write only loads a shadow copy. The six channel-pin levels move into the working copy on the first timer's transfer strobe, and the extra pin's level moves on the second timer's strobe. This lets each timer commit all of its PWM parameters together. A bus read returns the working copy. All pins and the read data are registered.

Top module: `pwm_out_polarity`

## Requirements
- R1: After a synchronous reset, every pin output is 0, and a register read returns 0x0000.
- R2: Each pin output is registered. One clock after a given cycle, it equals that cycle's working passive level when the pin's active input was 0, and the inverse of that level when the active input was 1.
- R3: Bits 5:0 of the register hold the channel-pin passive levels in this order: bit 2k is compare output k, and bit 2k+1 is complementary output k, for k = 0..2. A value of 1 means passive high and 0 means passive low.
- R4: Bit 7 of the register holds the passive level of the extra second-timer pin.
- R5: Bit 6 and bits 15:8 always read as 0, whatever was written to them.
- R6: The working bits 5:0 take the shadow bits 5:0 only in a cycle where `main_xfer` is 1. At all other times they hold their value.
- R7: The working bit 7 takes the shadow bit 7 only in a cycle where `aux_xfer` is 1. At all other times it holds its value.
- R8: A write cycle (`bus_sel` and `bus_wr` both 1) loads only the shadow. A read cycle (`bus_sel` and `bus_rd` both 1) places the working copy, as it stood in that cycle, on `bus_rdata` one clock later. Shadow values are never visible on a read.
- R9: When a write and a transfer strobe fall in the same cycle, the working copy takes the shadow value from before the write. The new value waits for the next strobe.
- R10: A write or read with `bus_sel` at 0 has no effect. In any cycle that follows a non-read cycle, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 16 | Write data (goes to the shadow) |
| bus_rdata | output | 16 | Registered read data (working copy) |
| main_xfer | input | 1 | First timer shadow-transfer strobe (bits 5:0) |
| aux_xfer | input | 1 | Second timer shadow-transfer strobe (bit 7) |
| cmp_act | input | 3 | Active state of each compare output |
| cmpn_act | input | 3 | Active state of each complementary output |
| aux_act | input | 1 | Active state of the extra output |
| cmp_out | output | 3 | Compare output pins |
| cmpn_out | output | 3 | Complementary output pins |
| aux_out | output | 1 | Extra output pin |

## Verification
The bench fires the two strobes on their own and reads the register after each. A design that shares one strobe between both groups would show bit 7 committed too early, or bits 5:0 committed on the wrong timer. The bench also writes a value in the same cycle as a strobe. A design that lets the write pass straight through to the working copy would read back the new value instead of the old shadow. Other checks write with `bus_sel` low, write all ones to catch reserved bits that read back as 1, and read between writes and strobes to catch reads that return the shadow. Random state, strobe and write traffic is then compared on every clock against a behavioural model, which catches a swapped compare/complement bit order or a missing output inversion.

// File: rtl/pol_pkg.sv
package pol_pkg;
  localparam int unsigned DEF_CHANNELS = 3;
  localparam int unsigned DEF_BUS_W    = 16;
  localparam int unsigned DEF_AUX_POS  = 7;
endpackage

// File: rtl/level_bank.sv
module level_bank #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_bits,
  input  logic         xfer,
  output logic [W-1:0] lvl
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] work_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      work_q   <= '0;
    end else begin
      if (xfer)  work_q   <= shadow_q;
      if (wr_en) shadow_q <= wr_bits;
    end
  end

  assign lvl = work_q;

  AST_HOLD_WITHOUT_XFER: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(lvl)); // R6

  AST_COMMIT_OLD_SHADOW: assert property (@(posedge clk) disable iff (rst)
    (xfer && wr_en) |=> (lvl == $past(shadow_q))); // R9
endmodule

// File: rtl/pin_drv.sv
module pin_drv #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] act,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] pin
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic pin_q;
    always_ff @(posedge clk) begin
      if (rst) pin_q <= 1'b0;
      else     pin_q <= act[i] ? ~lvl[i] : lvl[i];
    end
    assign pin[i] = pin_q;

    AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (pin[i] == ($past(act[i]) ^ $past(lvl[i])))); // R2
  end
endmodule

// File: rtl/pwm_out_polarity.sv
module pwm_out_polarity
  import pol_pkg::*;
#(
  parameter int unsigned CHANNELS = DEF_CHANNELS,
  parameter int unsigned BUS_W    = DEF_BUS_W,
  parameter int unsigned AUX_POS  = DEF_AUX_POS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                main_xfer,
  input  logic                aux_xfer,
  input  logic [CHANNELS-1:0] cmp_act,
  input  logic [CHANNELS-1:0] cmpn_act,
  input  logic                aux_act,
  output logic [CHANNELS-1:0] cmp_out,
  output logic [CHANNELS-1:0] cmpn_out,
  output logic                aux_out
);
  localparam int unsigned FLD_W  = 2 * CHANNELS;
  localparam int unsigned PINS_N = FLD_W + 1;

  logic             wr_hit;
  logic             rd_hit;
  logic [FLD_W-1:0] fld_lvl;
  logic [0:0]       aux_lvl;
  logic [PINS_N-1:0] act_vec;
  logic [PINS_N-1:0] pin_vec;
  logic [BUS_W-1:0] rd_word;
  logic [BUS_W-1:0] rdata_q;

  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & bus_rd;

  level_bank #(.W(FLD_W)) i_main_bank (
    .clk(clk), .rst(rst), .wr_en(wr_hit),
    .wr_bits(bus_wdata[FLD_W-1:0]), .xfer(main_xfer), .lvl(fld_lvl)
  );

  level_bank #(.W(1)) i_aux_bank (
    .clk(clk), .rst(rst), .wr_en(wr_hit),
    .wr_bits(bus_wdata[AUX_POS +: 1]), .xfer(aux_xfer), .lvl(aux_lvl)
  );

  for (genvar k = 0; k < CHANNELS; k++) begin : g_map
    assign act_vec[2*k]   = cmp_act[k];
    assign act_vec[2*k+1] = cmpn_act[k];
    assign cmp_out[k]     = pin_vec[2*k];
    assign cmpn_out[k]    = pin_vec[2*k+1];
  end
  assign act_vec[FLD_W] = aux_act;
  assign aux_out        = pin_vec[FLD_W];

  pin_drv #(.N(PINS_N)) i_pins (
    .clk(clk), .rst(rst), .act(act_vec), .lvl({aux_lvl, fld_lvl}), .pin(pin_vec)
  );

  always_comb begin
    rd_word = '0;
    rd_word[FLD_W-1:0] = fld_lvl;
    rd_word[AUX_POS]   = aux_lvl[0];
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_word;
    else             rdata_q <= '0;
  end
  assign bus_rdata = rdata_q;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[BUS_W-1:AUX_POS+1] == '0) && (bus_rdata[AUX_POS-1:FLD_W] == '0)); // R5

  AST_READ_WORKING: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (bus_rdata[FLD_W-1:0] == $past(fld_lvl))); // R8

  AST_AUX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !aux_xfer |=> $stable(aux_lvl)); // R7

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (bus_rdata == '0)); // R10
endmodule

// File: tb/test_pwm_out_polarity.sv
module test_pwm_out_polarity;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        main_xfer = 0, aux_xfer = 0;
  logic [2:0]  cmp_act = '0, cmpn_act = '0;
  logic        aux_act = 0;
  logic [2:0]  cmp_out, cmpn_out;
  logic        aux_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_out_polarity i_pwm_out_polarity (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .main_xfer(main_xfer),
    .aux_xfer(aux_xfer), .cmp_act(cmp_act), .cmpn_act(cmpn_act), .aux_act(aux_act),
    .cmp_out(cmp_out), .cmpn_out(cmpn_out), .aux_out(aux_out)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_shadow, m_work;
  logic [15:0] m_rdata;
  logic [2:0]  m_cmp, m_cmpn;
  logic        m_aux;

  always @(posedge clk) begin
    if (rst) begin
      m_shadow = 0; m_work = 0; m_rdata = 0; m_cmp = 0; m_cmpn = 0; m_aux = 0;
    end else begin
      m_rdata = (bus_sel && bus_rd) ? {8'h00, m_work & 8'hBF} : 16'h0;
      for (int k = 0; k < 3; k++) begin
        m_cmp[k]  = cmp_act[k]  ? ~m_work[2*k]   : m_work[2*k];
        m_cmpn[k] = cmpn_act[k] ? ~m_work[2*k+1] : m_work[2*k+1];
      end
      m_aux = aux_act ? ~m_work[7] : m_work[7];
      if (main_xfer) m_work[5:0] = m_shadow[5:0];
      if (aux_xfer)  m_work[7]   = m_shadow[7];
      if (bus_sel && bus_wr) m_shadow = bus_wdata[7:0] & 8'hBF;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R3 compare pins vs model", {13'b0, cmp_out}, {13'b0, m_cmp});
      check("R3 complement pins vs model", {13'b0, cmpn_out}, {13'b0, m_cmpn});
      check("R4 extra pin vs model", {15'b0, aux_out}, {15'b0, m_aux});
      check("R8 read data vs model", bus_rdata, m_rdata);
    end
  end

  task automatic cyc(logic s, logic w, logic r, logic [15:0] d, logic mx, logic ax);
    bus_sel = s; bus_wr = w; bus_rd = r; bus_wdata = d; main_xfer = mx; aux_xfer = ax;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_rd = 0; main_xfer = 0; aux_xfer = 0;
  endtask

  task automatic rd(output logic [15:0] v);
    cyc(1, 0, 1, 16'h0, 0, 0);
    v = bus_rdata;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 pins after reset", {9'b0, aux_out, cmpn_out, cmp_out}, 16'h0);
    rd(v); check("R1 readback after reset", v, 16'h0000);

    cyc(1, 1, 0, 16'h00A5, 0, 0);
    rd(v); check("R8 write without strobe hidden", v, 16'h0000);
    cyc(0, 0, 0, 16'h0, 1, 0);
    rd(v); check("R6 main strobe commits 5:0 only", v, 16'h0025);
    cyc(0, 0, 0, 16'h0, 0, 1);
    rd(v); check("R7 aux strobe commits bit 7", v, 16'h00A5);
    check("R3 passive compare levels", {13'b0, cmp_out}, 16'h0003);
    check("R3 passive complement levels", {13'b0, cmpn_out}, 16'h0004);
    check("R4 passive extra level", {15'b0, aux_out}, 16'h0001);

    cmp_act = 3'b111; cmpn_act = 3'b111; aux_act = 1;
    @(negedge clk);
    check("R2 active compare inverted", {13'b0, cmp_out}, 16'h0004);
    check("R2 active complement inverted", {13'b0, cmpn_out}, 16'h0003);
    check("R2 active extra inverted", {15'b0, aux_out}, 16'h0000);
    cmp_act = 0; cmpn_act = 0; aux_act = 0;

    cyc(1, 1, 0, 16'h0000, 0, 0);
    cyc(1, 1, 0, 16'hFFFF, 1, 1);
    rd(v); check("R9 same-cycle write takes old shadow", v, 16'h0000);
    cyc(0, 0, 0, 16'h0, 1, 1);
    rd(v); check("R5 reserved bits read zero", v, 16'h00BF);

    cyc(0, 1, 0, 16'h0000, 0, 0);
    cyc(0, 0, 0, 16'h0, 1, 1);
    rd(v); check("R10 unselected write ignored", v, 16'h00BF);
    cyc(0, 0, 1, 16'h0, 0, 0);
    check("R10 unselected read gives zero", bus_rdata, 16'h0000);

    for (int i = 0; i < 400; i++) begin
      cmp_act = 3'($urandom); cmpn_act = 3'($urandom); aux_act = 1'($urandom);
      cyc(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
          ($urandom % 5) == 0, ($urandom % 7) == 0);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule